// File: doc/BRIEF.md
# Dual Chip-Select Flash Request Dispatcher

This block sits between a local agent that issues flash commands and the SPI engine that drives two serial flash devices. Each request carries a command type, a linear byte address and a length. The dispatcher checks the request first: the transfer length, the erase size, the address range, and whether an earlier request is still in flight. A legal request is steered to one of two chip selects. The dispatcher also works out the address relative to that device and the SPI clock divider the engine should use.

The two devices share one linear space. A threshold value equals the size of the first device, and a limit value equals the combined size minus one. Each chip select has a 32-bit divider word. Its low half applies to reads and its high half applies to every other command. Erase sizes are turned into a compact code before dispatch, and only sizes the configuration allows get through. When the downstream engine reports completion, the block emits a done pulse and sets a sticky flag. Software clears that flag by writing a one.

Top module: `fcs_dispatch`

## Requirements
- R1: While reset is held, every output of the block is zero, including busy and the sticky done flag.
- R2: One clock after a legal request is sampled with req_valid high, disp_valid pulses for one cycle. If the address is below the threshold (config offset 0), disp_cs is 0 and disp_addr is the address itself. Otherwise disp_cs is 1 and disp_addr is the address minus the threshold.
- R3: The divider word for chip select 0 is at config offset 2 and the word for chip select 1 is at offset 3. For a read (code 0), disp_div is bits [15:0] of the selected word. For write (code 1) and erase (code 2), disp_div is bits [31:16].
- R4: A read or write whose length is 0 or greater than 64 raises err_len for one cycle and is not dispatched. Lengths 1 to 64 are accepted.
- R5: An erase with length 4096 is always accepted, with disp_ecode 0. Length 32768 is accepted with code 1 only when bit 0 of the erase bitmap (config offset 4) is set. Length 65536 is accepted with code 2 only when bit 1 of that bitmap is set. Any other erase raises err_erase and is not dispatched.
- R6: Command code 3 is not a valid command. It raises err_len and is not dispatched.
- R7: A request whose address is greater than the limit (config offset 1) raises err_range and is not dispatched. An address equal to the limit is legal.
- R8: After a dispatch, busy stays high until the engine reports completion. A request made while busy gets only a one-cycle err_busy. It causes no dispatch and leaves busy unchanged.
- R9: When eng_done is high while the block is busy, busy clears and done_pulse rises for exactly one cycle on the next clock, and done_sticky sets. When eng_done is high while the block is idle, nothing changes.
- R10: Writing config offset 5 with bit 0 set clears done_sticky. A write there with bit 0 clear has no effect. If a completion and a clear happen in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present this cycle |
| req_cmd | input | 2 | Command type: 0 read, 1 write, 2 erase |
| req_addr | input | AW | Linear flash byte address |
| req_len | input | LW | Byte count or erase size |
| eng_done | input | 1 | Completion from the downstream engine |
| disp_valid | output | 1 | One-cycle dispatch strobe |
| disp_cs | output | 1 | Selected chip select |
| disp_cmd | output | 2 | Dispatched command type |
| disp_addr | output | AW | Address relative to the chip select |
| disp_len | output | LW | Dispatched length |
| disp_div | output | DIVW | Clock divider for this command |
| disp_ecode | output | 2 | Encoded erase size |
| err_busy | output | 1 | Refused because a request is in flight |
| err_len | output | 1 | Bad length or bad command code |
| err_erase | output | 1 | Erase size not supported |
| err_range | output | 1 | Address beyond limit |
| busy | output | 1 | A dispatched request is outstanding |
| done_pulse | output | 1 | One-cycle completion pulse |
| done_sticky | output | 1 | Completion flag, cleared by writing 1 |

## Verification
The hardest cases to reach from the ports are the ones that depend on timing between a request and the engine's completion. Examples are a new request arriving while the previous one is still outstanding, and a completion landing in the same cycle as a sticky-flag clear. The stimulus holds a dispatched request open on purpose and does not answer it. It then injects a second request, and later drives eng_done and the clear write on the same clock edge. Address sweeps cross the threshold and the limit one byte at a time. Erase sizes are swept against all four bitmap settings.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    typedef enum logic [1:0] {
        CMD_RD  = 2'd0,
        CMD_WR  = 2'd1,
        CMD_ER  = 2'd2,
        CMD_BAD = 2'd3
    } fcs_cmd_e;

    localparam int unsigned CFG_AW = 3;
    localparam int unsigned CFG_DW = 32;

    localparam logic [CFG_AW-1:0] REG_THR  = 3'd0;
    localparam logic [CFG_AW-1:0] REG_LIM  = 3'd1;
    localparam logic [CFG_AW-1:0] REG_DIV0 = 3'd2;
    localparam logic [CFG_AW-1:0] REG_EBM  = 3'd4;
    localparam logic [CFG_AW-1:0] REG_STAT = 3'd5;
endpackage

// File: rtl/fcs_cfg_regs.sv
module fcs_cfg_regs
    import fcs_pkg::*;
#(
    parameter int unsigned AW   = 24,
    parameter int unsigned DIVW = 16,
    parameter int unsigned NCS  = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [CFG_AW-1:0]              cfg_addr,
    input  logic [CFG_DW-1:0]              cfg_wdata,
    output logic [AW-1:0]                  thr_o,
    output logic [AW-1:0]                  lim_o,
    output logic [NCS-1:0][2*DIVW-1:0]     div_o,
    output logic [1:0]                     ebm_o,
    output logic                           clr_done_o
);
    localparam int unsigned WW = 2 * DIVW;

    typedef struct packed {
        logic [AW-1:0]          thr;
        logic [AW-1:0]          lim;
        logic [NCS-1:0][WW-1:0] div;
        logic [1:0]             ebm;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [NCS-1:0] div_hit;

    for (genvar g = 0; g < NCS; g++) begin : g_div_hit
        assign div_hit[g] = cfg_we && (cfg_addr == (REG_DIV0 + CFG_AW'(g)));
    end

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we && cfg_addr == REG_THR) cfg_d.thr = cfg_wdata[AW-1:0];
        if (cfg_we && cfg_addr == REG_LIM) cfg_d.lim = cfg_wdata[AW-1:0];
        if (cfg_we && cfg_addr == REG_EBM) cfg_d.ebm = cfg_wdata[1:0];
        for (int i = 0; i < NCS; i++) begin
            if (div_hit[i]) cfg_d.div[i] = cfg_wdata[WW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign thr_o      = cfg_q.thr;
    assign lim_o      = cfg_q.lim;
    assign div_o      = cfg_q.div;
    assign ebm_o      = cfg_q.ebm;
    assign clr_done_o = cfg_we && (cfg_addr == REG_STAT) && cfg_wdata[0];
endmodule

// File: rtl/fcs_req_check.sv
module fcs_req_check
    import fcs_pkg::*;
#(
    parameter int unsigned AW     = 24,
    parameter int unsigned LW     = 20,
    parameter int unsigned DIVW   = 16,
    parameter int unsigned NCS    = 2,
    parameter int unsigned MAX_RW = 64
) (
    input  logic [1:0]                 cmd,
    input  logic [AW-1:0]              addr,
    input  logic [LW-1:0]              len,
    input  logic [AW-1:0]              thr,
    input  logic [AW-1:0]              lim,
    input  logic [NCS-1:0][2*DIVW-1:0] div,
    input  logic [1:0]                 ebm,
    output logic                       bad_len,
    output logic                       bad_erase,
    output logic                       bad_range,
    output logic                       cs,
    output logic [AW-1:0]              rel_addr,
    output logic [DIVW-1:0]            div_sel,
    output logic [1:0]                 ecode
);
    localparam logic [LW-1:0] ER_SMALL = LW'(4096);
    localparam logic [LW-1:0] ER_MID   = LW'(32768);
    localparam logic [LW-1:0] ER_BIG   = LW'(65536);
    localparam logic [LW-1:0] RW_MAX   = LW'(MAX_RW);

    logic [2*DIVW-1:0] word;

    always_comb begin
        bad_len   = 1'b0;
        bad_erase = 1'b0;
        ecode     = 2'd0;
        case (fcs_cmd_e'(cmd))
            CMD_RD, CMD_WR: bad_len = (len == '0) || (len > RW_MAX);
            CMD_ER: begin
                if (len == ER_SMALL)                ecode = 2'd0;
                else if (len == ER_MID && ebm[0])   ecode = 2'd1;
                else if (len == ER_BIG && ebm[1])   ecode = 2'd2;
                else                                bad_erase = 1'b1;
            end
            default: bad_len = 1'b1;
        endcase

        bad_range = addr > lim;
        cs        = addr >= thr;
        rel_addr  = cs ? (addr - thr) : addr;
        word      = div[cs];
        div_sel   = (fcs_cmd_e'(cmd) == CMD_RD) ? word[DIVW-1:0] : word[2*DIVW-1:DIVW];
    end
endmodule

// File: rtl/fcs_dispatch.sv
module fcs_dispatch
    import fcs_pkg::*;
#(
    parameter int unsigned AW     = 24,
    parameter int unsigned LW     = 20,
    parameter int unsigned DIVW   = 16,
    parameter int unsigned MAX_RW = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    input  logic             req_valid,
    input  logic [1:0]       req_cmd,
    input  logic [AW-1:0]    req_addr,
    input  logic [LW-1:0]    req_len,
    input  logic             eng_done,
    output logic             disp_valid,
    output logic             disp_cs,
    output logic [1:0]       disp_cmd,
    output logic [AW-1:0]    disp_addr,
    output logic [LW-1:0]    disp_len,
    output logic [DIVW-1:0]  disp_div,
    output logic [1:0]       disp_ecode,
    output logic             err_busy,
    output logic             err_len,
    output logic             err_erase,
    output logic             err_range,
    output logic             busy,
    output logic             done_pulse,
    output logic             done_sticky
);
    localparam int unsigned NCS = 2;

    typedef struct packed {
        logic            busy;
        logic            disp_valid;
        logic            disp_cs;
        logic [1:0]      disp_cmd;
        logic [AW-1:0]   disp_addr;
        logic [LW-1:0]   disp_len;
        logic [DIVW-1:0] disp_div;
        logic [1:0]      disp_ecode;
        logic            err_busy;
        logic            err_len;
        logic            err_erase;
        logic            err_range;
        logic            done_pulse;
        logic            done_sticky;
    } st_t;

    st_t st_d, st_q;

    logic [AW-1:0]              thr_w, lim_w, rel_w;
    logic [NCS-1:0][2*DIVW-1:0] div_w;
    logic [1:0]                 ebm_w, ecode_w;
    logic                       clr_w, bad_len_w, bad_er_w, bad_rng_w, cs_w;
    logic [DIVW-1:0]            dsel_w;

    fcs_cfg_regs #(.AW(AW), .DIVW(DIVW), .NCS(NCS)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .thr_o      (thr_w),
        .lim_o      (lim_w),
        .div_o      (div_w),
        .ebm_o      (ebm_w),
        .clr_done_o (clr_w)
    );

    fcs_req_check #(.AW(AW), .LW(LW), .DIVW(DIVW), .NCS(NCS), .MAX_RW(MAX_RW)) u_chk_req (
        .cmd       (req_cmd),
        .addr      (req_addr),
        .len       (req_len),
        .thr       (thr_w),
        .lim       (lim_w),
        .div       (div_w),
        .ebm       (ebm_w),
        .bad_len   (bad_len_w),
        .bad_erase (bad_er_w),
        .bad_range (bad_rng_w),
        .cs        (cs_w),
        .rel_addr  (rel_w),
        .div_sel   (dsel_w),
        .ecode     (ecode_w)
    );

    always_comb begin
        st_d            = st_q;
        st_d.disp_valid = 1'b0;
        st_d.err_busy   = 1'b0;
        st_d.err_len    = 1'b0;
        st_d.err_erase  = 1'b0;
        st_d.err_range  = 1'b0;
        st_d.done_pulse = 1'b0;

        if (clr_w) st_d.done_sticky = 1'b0;
        if (st_q.busy && eng_done) begin
            st_d.busy        = 1'b0;
            st_d.done_pulse  = 1'b1;
            st_d.done_sticky = 1'b1;
        end

        if (req_valid) begin
            if (st_q.busy) begin
                st_d.err_busy = 1'b1;
            end else begin
                st_d.err_len   = bad_len_w;
                st_d.err_erase = bad_er_w;
                st_d.err_range = bad_rng_w;
                if (!bad_len_w && !bad_er_w && !bad_rng_w) begin
                    st_d.disp_valid = 1'b1;
                    st_d.busy       = 1'b1;
                    st_d.disp_cs    = cs_w;
                    st_d.disp_cmd   = req_cmd;
                    st_d.disp_addr  = rel_w;
                    st_d.disp_len   = req_len;
                    st_d.disp_div   = dsel_w;
                    st_d.disp_ecode = ecode_w;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign disp_valid  = st_q.disp_valid;
    assign disp_cs     = st_q.disp_cs;
    assign disp_cmd    = st_q.disp_cmd;
    assign disp_addr   = st_q.disp_addr;
    assign disp_len    = st_q.disp_len;
    assign disp_div    = st_q.disp_div;
    assign disp_ecode  = st_q.disp_ecode;
    assign err_busy    = st_q.err_busy;
    assign err_len     = st_q.err_len;
    assign err_erase   = st_q.err_erase;
    assign err_range   = st_q.err_range;
    assign busy        = st_q.busy;
    assign done_pulse  = st_q.done_pulse;
    assign done_sticky = st_q.done_sticky;
endmodule

// File: rtl/fcs_dispatch_chk.sv
module fcs_dispatch_chk #(
    parameter int unsigned AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic          eng_done,
    input logic [AW-1:0] thr,
    input logic [AW-1:0] lim,
    input logic          disp_valid,
    input logic          disp_cs,
    input logic          err_busy,
    input logic          err_len,
    input logic          err_erase,
    input logic          err_range,
    input logic          busy,
    input logic          done_pulse,
    input logic          done_sticky
);
    a_r8_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        busy && req_valid |=> err_busy && !disp_valid);

    a_r8_dispatch_holds_busy: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> busy);

    a_r4_error_blocks_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
        (err_len || err_erase || err_range || err_busy) |-> !disp_valid);

    a_r7_dispatch_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> $past(req_addr) <= $past(lim));

    a_r2_cs_follows_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> disp_cs == ($past(req_addr) >= $past(thr)));

    a_r9_idle_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && eng_done |=> !done_pulse);

    a_r9_done_frees_and_flags: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> !busy && done_sticky);
endmodule

bind fcs_dispatch fcs_dispatch_chk #(.AW(AW)) u_fcs_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .eng_done    (eng_done),
    .thr         (thr_w),
    .lim         (lim_w),
    .disp_valid  (disp_valid),
    .disp_cs     (disp_cs),
    .err_busy    (err_busy),
    .err_len     (err_len),
    .err_erase   (err_erase),
    .err_range   (err_range),
    .busy        (busy),
    .done_pulse  (done_pulse),
    .done_sticky (done_sticky)
);

// File: tb/fcs_dispatch_tb_top.sv
module fcs_dispatch_tb_top;
    localparam int AW = 24;
    localparam int LW = 20;
    localparam logic [AW-1:0] THR  = 24'h004000;
    localparam logic [AW-1:0] LIM  = 24'h009FFF;
    localparam logic [31:0]   DIV0 = 32'h0011_0022;
    localparam logic [31:0]   DIV1 = 32'h0033_0044;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic req_valid = 1'b0;
    logic [1:0] req_cmd = '0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic eng_done = 1'b0;

    logic disp_valid, disp_cs, err_busy, err_len, err_erase, err_range;
    logic busy, done_pulse, done_sticky;
    logic [1:0] disp_cmd, disp_ecode;
    logic [AW-1:0] disp_addr;
    logic [LW-1:0] disp_len;
    logic [15:0] disp_div;

    int total = 0;
    int fails = 0;
    logic [1:0] ebm = 2'b00;

    always #2 clk = ~clk;

    fcs_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len),
        .eng_done(eng_done), .disp_valid(disp_valid), .disp_cs(disp_cs), .disp_cmd(disp_cmd),
        .disp_addr(disp_addr), .disp_len(disp_len), .disp_div(disp_div), .disp_ecode(disp_ecode),
        .err_busy(err_busy), .err_len(err_len), .err_erase(err_erase), .err_range(err_range),
        .busy(busy), .done_pulse(done_pulse), .done_sticky(done_sticky)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic finish_op();
        @(negedge clk);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        chk("R9", "done_pulse", done_pulse, 1);
        chk("R9", "busy cleared", busy, 0);
        chk("R9", "sticky set", done_sticky, 1);
        @(negedge clk);
        chk("R9", "pulse one cycle", done_pulse, 0);
        cfg_write(3'd5, 32'h1);
        chk("R10", "sticky cleared", done_sticky, 0);
    endtask

    task automatic send(input logic [1:0] c, input logic [AW-1:0] a, input logic [LW-1:0] l, input bit hold);
        bit e_len, e_er, e_rng, ok, cs;
        logic [31:0] word;
        logic [1:0] code;
        e_len = (c <= 2'd1) ? (l == 0 || l > 64) : (c == 2'd3);
        e_er  = (c == 2'd2) && !(l == 4096 || (l == 32768 && ebm[0]) || (l == 65536 && ebm[1]));
        e_rng = a > LIM;
        ok    = !e_len && !e_er && !e_rng;
        cs    = a >= THR;
        word  = cs ? DIV1 : DIV0;
        code  = (l == 4096) ? 2'd0 : (l == 32768) ? 2'd1 : 2'd2;
        @(negedge clk);
        req_valid = 1'b1; req_cmd = c; req_addr = a; req_len = l;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R4", "err_len", err_len, e_len);
        chk("R5", "err_erase", err_erase, e_er);
        chk("R7", "err_range", err_range, e_rng);
        chk("R2", "disp_valid", disp_valid, ok);
        chk("R8", "no err_busy when idle", err_busy, 0);
        if (ok) begin
            chk("R2", "disp_cs", disp_cs, cs);
            chk("R2", "disp_addr", disp_addr, cs ? a - THR : a);
            chk("R3", "disp_div", disp_div, (c == 2'd0) ? word[15:0] : word[31:16]);
            chk("R2", "disp_cmd", disp_cmd, c);
            chk("R2", "disp_len", disp_len, l);
            if (c == 2'd2) chk("R5", "disp_ecode", disp_ecode, code);
            chk("R8", "busy after dispatch", busy, 1);
            if (!hold) finish_op();
        end else begin
            chk("R8", "idle after reject", busy, 0);
        end
    endtask

    initial begin
        #800000;
        total++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "disp_valid", disp_valid, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "sticky", done_sticky, 0);
        chk("R1", "errors", {err_busy, err_len, err_erase, err_range}, 0);
        chk("R1", "done_pulse", done_pulse, 0);
        chk("R1", "disp fields", {disp_cs, disp_cmd, disp_addr, disp_len, disp_div, disp_ecode}, 0);
        rst_n = 1'b1;

        cfg_write(3'd0, 32'(THR));
        cfg_write(3'd1, 32'(LIM));
        cfg_write(3'd2, DIV0);
        cfg_write(3'd3, DIV1);
        cfg_write(3'd4, 32'h0);

        // R4: read and write length sweep
        for (int n = 0; n <= 70; n++) send(2'd0, 24'h000100, LW'(n), 1'b0);
        for (int n = 0; n <= 66; n += 3) send(2'd1, 24'h005000, LW'(n), 1'b0);
        send(2'd1, 24'h005000, 20'd64, 1'b0);

        // R2, R3, R7: addresses across the threshold and the limit
        send(2'd0, THR - 1, 20'd4, 1'b0);
        send(2'd0, THR,     20'd4, 1'b0);
        send(2'd1, THR + 1, 20'd4, 1'b0);
        send(2'd0, 24'h0,   20'd1, 1'b0);
        send(2'd1, LIM,     20'd1, 1'b0);
        send(2'd0, LIM + 1, 20'd1, 1'b0);
        send(2'd0, 24'hFFFFFF, 20'd8, 1'b0);
        for (int a = 0; a < 24'hC000; a += 24'h0FFF) send(2'(a % 2), AW'(a), 20'd16, 1'b0);

        // R5: erase sizes against every bitmap setting
        for (int b = 0; b < 4; b++) begin
            ebm = 2'(b);
            cfg_write(3'd4, 32'(b));
            send(2'd2, 24'h002000, 20'd4096, 1'b0);
            send(2'd2, 24'h006000, 20'd32768, 1'b0);
            send(2'd2, 24'h008000, 20'd65536, 1'b0);
            send(2'd2, 24'h002000, 20'd4095, 1'b0);
            send(2'd2, 24'h002000, 20'd8192, 1'b0);
            send(2'd2, 24'h002000, 20'd0, 1'b0);
            send(2'd2, 24'h002000, 20'd131072, 1'b0);
        end

        // R7 and R4 together: several flags at once
        send(2'd0, LIM + 2, 20'd0, 1'b0);
        // R6: command code 3
        send(2'd3, 24'h000010, 20'd4, 1'b0);

        // R8: request while busy is refused
        send(2'd0, 24'h000020, 20'd8, 1'b1);
        @(negedge clk);
        req_valid = 1'b1; req_cmd = 2'd1; req_addr = 24'h005555; req_len = 20'd4;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8", "err_busy", err_busy, 1);
        chk("R8", "no dispatch while busy", disp_valid, 0);
        chk("R8", "still busy", busy, 1);
        chk("R8", "earlier dispatch kept", disp_addr, 24'h000020);
        chk("R8", "no other error", {err_len, err_erase, err_range}, 0);

        // R10: completion and clear in the same cycle, set wins
        @(negedge clk);
        eng_done = 1'b1; cfg_we = 1'b1; cfg_addr = 3'd5; cfg_wdata = 32'h1;
        @(negedge clk);
        eng_done = 1'b0; cfg_we = 1'b0;
        chk("R10", "set beats clear", done_sticky, 1);
        chk("R9", "done_pulse", done_pulse, 1);
        cfg_write(3'd5, 32'h0);
        chk("R10", "write of zero ignored", done_sticky, 1);
        cfg_write(3'd5, 32'h1);
        chk("R10", "cleared", done_sticky, 0);

        // R9: completion while idle is ignored
        @(negedge clk);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        chk("R9", "no pulse when idle", done_pulse, 0);
        chk("R9", "sticky stays clear", done_sticky, 0);
        chk("R9", "busy stays low", busy, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule